// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits at the head of a receive path and decides, once per frame, whether the frame is kept or dropped. It looks only at the destination address. The address arrives as a stream of six octets, in the order they were received. While the octets arrive, the block builds two results in parallel. The first is an exact comparison against the configured station address. The second is a CRC-32 over the address, whose top bits pick one bit of a 64-bit hash table.

When the last address octet has been taken, the block combines four things into one registered verdict: the two match results, the address class, and the mode inputs. The mode inputs are promiscuous mode, the physical-address reject mode and a two-bit multicast mode. A one-cycle done pulse marks the new verdict. The verdict stays on its output until the next frame is decided, so a downstream stage may sample it at any later time.

Top module: `rx_addr_filter`

## Requirements
- R1: While reset is asserted, and after it until the first decision, `doneOut` and `acceptOut` are 0.
- R2: An octet is taken on a clock edge where `addrValid` is 1. An octet with `addrFirst` = 1 is octet 0 of a new address. Octet k fills bits [8k+7:8k] of the address, so the first octet received is bits [7:0]. `doneOut` is 1 for exactly one cycle, the cycle after octet 5 is taken. A verdict that turns over from the previous one also changes in that same cycle.
- R3: With `promiscIn` = 1, every frame is accepted, whatever the match results and the multicast mode.
- R4: A physical frame whose address equals `stationAddr` is accepted while `physRejectIn` = 0.
- R5: While `physRejectIn` = 0, a physical frame is accepted on a hash hit, and rejected when it has neither a hash hit nor a perfect match. The hash index is bits [31:26] of a CRC-32 register taken after all 48 address bits. The register starts at all ones and uses the reflected polynomial 0xEDB88320. Bits enter least significant first, octet 0 first, and the result is not complemented. A hit means `hashTable[index]` = 1.
- R6: While `physRejectIn` = 1, a physical frame is rejected if it perfectly matches `stationAddr`, and accepted otherwise, including hash-only hits and total misses.
- R7: A frame is multicast when bit 0 of octet 0 is 1, and physical otherwise. The broadcast address counts as multicast. `physRejectIn` has no effect on multicast frames.
- R8: Without promiscuous mode, a multicast frame is decided by `mcastMode` alone. 2'b00 rejects it. 2'b01 accepts it only on a hash hit. 2'b10 and 2'b11 accept every multicast frame.
- R9: `acceptOut` holds its value in every cycle in which `doneOut` is 0.
- R10: Octets that arrive with `addrValid` = 1 outside an address (no `addrFirst` since the last decision) are ignored. An octet with `addrFirst` = 1 in the middle of an address drops the partial address and starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrValid | input | 1 | An address octet is present on `addrOctet` |
| addrFirst | input | 1 | Marks octet 0 of a destination address |
| addrOctet | input | 8 | Address octet, in the order received |
| stationAddr | input | 48 | Station address, octet 0 in bits [7:0] |
| hashTable | input | 64 | Hash filter table, indexed by the CRC hash |
| promiscIn | input | 1 | Accept all frames |
| physRejectIn | input | 1 | Invert the rule for physical addresses |
| mcastMode | input | 2 | Multicast acceptance mode |
| doneOut | output | 1 | One-cycle pulse marking a new verdict |
| acceptOut | output | 1 | Verdict of the latest decision, held |

## Verification
The bench builds the block with its default parameters: six address octets, a 6-bit hash index and a 32-bit CRC. With these values, the real Ethernet hash index is computed, and the bench can derive it on its own by bit-serial CRC arithmetic. So it can set exactly the table bit that a chosen address hits. The six-octet window also leaves room for edge cases. The bench can abandon an address after three octets and restart it with a new first marker. It can also feed stray octets between frames and check that no decision results.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;   // octet 0 of a new address is on the input
    logic take;    // the present octet belongs to the address
  } filtStrobe_t;

  // Combinational results from datapath to control
  typedef struct packed {
    logic lastOctet;   // the octet being taken completes the address
    logic perfectHit;  // full address equals the station address
    logic hashHit;     // hash table bit selected by the CRC is set
    logic multicast;   // group bit of octet 0 is set
  } filtFlags_t;

  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } filtState_t;

endpackage

// File: rtl/rx_addr_filter_dp.sv
module rx_addr_filter_dp
  import rx_addr_filter_pkg::*;
#(
  parameter int ADDR_OCTETS = 6,
  parameter int HASH_BITS   = 6,
  parameter int CRC_WIDTH   = 32,
  parameter logic [CRC_WIDTH-1:0] CRC_POLY = 32'hEDB88320
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  filtStrobe_t               strobe,
  input  logic [7:0]                addrOctet,
  input  logic [ADDR_OCTETS*8-1:0]  stationAddr,
  input  logic [(1<<HASH_BITS)-1:0] hashTable,
  output filtFlags_t                flags
);

  localparam int ADDR_W = ADDR_OCTETS * 8;
  localparam int CNT_W  = $clog2(ADDR_OCTETS + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ADDR_OCTETS - 1);

  logic [ADDR_W-1:0]    addrReg, addrNext;
  logic [CRC_WIDTH-1:0] crcReg, crcSeed, crcNext;
  logic [CNT_W-1:0]     octetCnt, posNow;
  logic [HASH_BITS-1:0] hashIdx;

  // Reflected CRC update over one octet, least significant bit first
  function automatic logic [CRC_WIDTH-1:0] crcOctet(
    input logic [CRC_WIDTH-1:0] crcIn,
    input logic [7:0]           dataIn
  );
    logic [CRC_WIDTH-1:0] c;
    logic fb;
    c = crcIn;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ dataIn[b];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

  assign posNow  = strobe.start ? '0 : octetCnt;
  assign crcSeed = strobe.start ? '1 : crcReg;
  assign crcNext = crcOctet(crcSeed, addrOctet);

  always_comb begin
    addrNext = addrReg;
    for (int k = 0; k < ADDR_OCTETS; k++) begin
      if (posNow == CNT_W'(k)) addrNext[k*8 +: 8] = addrOctet;
    end
  end

  assign hashIdx          = crcNext[CRC_WIDTH-1 -: HASH_BITS];
  assign flags.lastOctet  = (posNow == LAST_POS);
  assign flags.perfectHit = (addrNext == stationAddr);
  assign flags.hashHit    = hashTable[hashIdx];
  assign flags.multicast  = addrNext[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      crcReg   <= '1;
      octetCnt <= '0;
    end else if (strobe.take) begin
      addrReg  <= addrNext;
      crcReg   <= crcNext;
      octetCnt <= posNow + CNT_W'(1);
    end
  end

endmodule

// File: rtl/rx_addr_filter_ctl.sv
module rx_addr_filter_ctl
  import rx_addr_filter_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrValid,
  input  logic        addrFirst,
  input  logic        promiscIn,
  input  logic        physRejectIn,
  input  logic [1:0]  mcastMode,
  input  filtFlags_t  flags,
  output filtStrobe_t strobe,
  output logic        doneOut,
  output logic        acceptOut
);

  filtState_t state, stateNext;
  logic decide, verdict;

  assign strobe.start = addrValid && addrFirst;
  assign strobe.take  = addrValid && (addrFirst || state == ST_COLLECT);
  assign decide       = strobe.take && flags.lastOctet;

  always_comb begin
    stateNext = state;
    if (decide)            stateNext = ST_IDLE;
    else if (strobe.start) stateNext = ST_COLLECT;
  end

  always_comb begin
    if (promiscIn) begin
      verdict = 1'b1;
    end else if (flags.multicast) begin
      unique case (mcastMode)
        2'b00:   verdict = 1'b0;
        2'b01:   verdict = flags.hashHit;
        default: verdict = 1'b1;
      endcase
    end else if (physRejectIn) begin
      verdict = !flags.perfectHit;
    end else begin
      verdict = flags.perfectHit || flags.hashHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      doneOut   <= 1'b0;
      acceptOut <= 1'b0;
    end else begin
      state   <= stateNext;
      doneOut <= decide;
      if (decide) acceptOut <= verdict;
    end
  end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rx_addr_filter_pkg::*;
#(
  parameter int ADDR_OCTETS = 6,
  parameter int HASH_BITS   = 6,
  parameter int CRC_WIDTH   = 32,
  parameter logic [CRC_WIDTH-1:0] CRC_POLY = 32'hEDB88320
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        addrValid,
  input  logic                        addrFirst,
  input  logic [7:0]                  addrOctet,
  input  logic [ADDR_OCTETS*8-1:0]    stationAddr,
  input  logic [(1<<HASH_BITS)-1:0]   hashTable,
  input  logic                        promiscIn,
  input  logic                        physRejectIn,
  input  logic [1:0]                  mcastMode,
  output logic                        doneOut,
  output logic                        acceptOut
);

  filtStrobe_t strobe;
  filtFlags_t  flags;

  rx_addr_filter_dp #(
    .ADDR_OCTETS (ADDR_OCTETS),
    .HASH_BITS   (HASH_BITS),
    .CRC_WIDTH   (CRC_WIDTH),
    .CRC_POLY    (CRC_POLY)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addrOctet   (addrOctet),
    .stationAddr (stationAddr),
    .hashTable   (hashTable),
    .flags       (flags)
  );

  rx_addr_filter_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .addrValid    (addrValid),
    .addrFirst    (addrFirst),
    .promiscIn    (promiscIn),
    .physRejectIn (physRejectIn),
    .mcastMode    (mcastMode),
    .flags        (flags),
    .strobe       (strobe),
    .doneOut      (doneOut),
    .acceptOut    (acceptOut)
  );

endmodule

// File: rtl/rx_addr_filter_chk.sv
module rx_addr_filter_chk (
  input logic clk,
  input logic rstN,
  input logic addrValid,
  input logic promiscIn,
  input logic doneOut,
  input logic acceptOut
);

  // R2
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);

  // R2
  done_after_octet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> $past(addrValid));

  // R3
  promisc_accepts_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && $past(promiscIn)) |-> acceptOut);

  // R9
  verdict_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> $stable(acceptOut));

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .addrValid (addrValid),
  .promiscIn (promiscIn),
  .doneOut   (doneOut),
  .acceptOut (acceptOut)
);

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrValid = 1'b0;
  logic        addrFirst = 1'b0;
  logic [7:0]  addrOctet = 8'h00;
  logic [47:0] stationAddr = 48'h0;
  logic [63:0] hashTable = 64'h0;
  logic        promiscIn = 1'b0;
  logic        physRejectIn = 1'b0;
  logic [1:0]  mcastMode = 2'b00;
  logic        doneOut, acceptOut;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrFirst(addrFirst),
    .addrOctet(addrOctet), .stationAddr(stationAddr), .hashTable(hashTable),
    .promiscIn(promiscIn), .physRejectIn(physRejectIn), .mcastMode(mcastMode),
    .doneOut(doneOut), .acceptOut(acceptOut)
  );

  // Hash index by bit-serial CRC over the 48 address bits
  function automatic int refHash(input logic [47:0] a);
    logic [31:0] crc = 32'hFFFFFFFF;
    logic fb;
    for (int j = 0; j < 48; j++) begin
      fb  = crc[0] ^ a[j];
      crc = crc >> 1;
      if (fb) crc = crc ^ 32'hEDB88320;
    end
    return int'(crc[31:26]);
  endfunction

  function automatic bit refAccept(input logic [47:0] a);
    bit hashHit = hashTable[refHash(a)];
    bit perfect = (a == stationAddr);
    if (promiscIn) return 1'b1;
    if (a[0]) begin
      if (mcastMode == 2'b00) return 1'b0;
      if (mcastMode == 2'b01) return hashHit;
      return 1'b1;
    end
    if (physRejectIn) return !perfect;
    return perfect || hashHit;
  endfunction

  // Reference model, stepped on each rising edge
  int          mCnt = 0;
  bit          mActive = 0;
  logic [47:0] mAddr = 48'h0;
  bit          expDone = 0;
  bit          expAcc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mActive = 0; expDone = 0; expAcc = 0;
    end else begin
      expDone = 0;
      if (addrValid) begin
        if (addrFirst) begin
          mCnt = 0; mActive = 1;
        end
        if (mActive) begin
          mAddr[8*mCnt +: 8] = addrOctet;
          mCnt++;
          if (mCnt == 6) begin
            expDone = 1;
            expAcc  = refAccept(mAddr);
            mActive = 0;
          end
        end
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    checks++;
    if (doneOut !== expDone || (!rstN && doneOut !== 1'b0)) begin
      errors++;
      $display("FAIL %s (R2 done timing) t=%0t done=%b expected %b", curReq, $time, doneOut, expDone);
    end
    checks++;
    if (acceptOut !== expAcc) begin
      errors++;
      if (expDone)
        $display("FAIL %s verdict t=%0t accept=%b expected %b", curReq, $time, acceptOut, expAcc);
      else
        $display("FAIL R9 held verdict (%s) t=%0t accept=%b expected %b", curReq, $time, acceptOut, expAcc);
    end
  end

  task automatic sendOctets(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      addrValid = 1'b1;
      addrFirst = (k == 0);
      addrOctet = a[8*k +: 8];
    end
    @(negedge clk);
    addrValid = 1'b0;
    addrFirst = 1'b0;
  endtask

  task automatic sendFrame(input logic [47:0] a);
    sendOctets(a, 6);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [47:0] STATION = 48'h6655_4433_2210;
  localparam logic [47:0] PHYS_X  = 48'hA1B2_C3D4_E5F6;
  localparam logic [47:0] PHYS_Y  = 48'h0102_0304_0508;
  localparam logic [47:0] MCAST_M = 48'h0000_5E00_0001;
  localparam logic [47:0] MCAST_N = 48'h9988_7766_5533;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;

  bit finished = 0;

  initial begin
    stationAddr = STATION;
    curReq = "R1";
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R4 perfect match
    curReq = "R4";
    sendFrame(STATION);
    sendFrame(PHYS_Y);

    // R5 hash hit and miss
    curReq = "R5";
    hashTable = 64'h1 << refHash(PHYS_X);
    sendFrame(PHYS_X);
    sendFrame(PHYS_Y);

    // R6 inverted physical rule
    curReq = "R6";
    physRejectIn = 1'b1;
    sendFrame(STATION);
    sendFrame(PHYS_X);
    sendFrame(STATION);
    sendFrame(PHYS_Y);

    // R7 multicast classification, reject bit ignored
    curReq = "R7";
    mcastMode = 2'b00;
    sendFrame(MCAST_N);
    sendFrame(BCAST);
    mcastMode = 2'b10;
    sendFrame(BCAST);
    physRejectIn = 1'b0;
    sendFrame(MCAST_N);

    // R8 multicast modes
    curReq = "R8";
    hashTable = 64'h1 << refHash(MCAST_M);
    mcastMode = 2'b01;
    sendFrame(MCAST_M);
    sendFrame(MCAST_N);
    mcastMode = 2'b00;
    sendFrame(MCAST_M);
    mcastMode = 2'b11;
    sendFrame(MCAST_N);

    // R3 promiscuous
    curReq = "R3";
    promiscIn = 1'b1;
    mcastMode = 2'b00;
    hashTable = 64'h0;
    sendFrame(MCAST_N);
    sendFrame(PHYS_Y);
    promiscIn = 1'b0;
    sendFrame(PHYS_Y);

    // R10 stray octets and restart
    curReq = "R10";
    sendFrame(STATION);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      addrValid = 1'b1;
      addrFirst = 1'b0;
      addrOctet = 8'(k * 17);
    end
    @(negedge clk);
    addrValid = 1'b0;
    repeat (3) @(negedge clk);
    sendOctets(PHYS_Y, 3);
    sendFrame(STATION);
    sendOctets(PHYS_Y, 4);
    sendFrame(PHYS_Y);

    // R2 back-to-back frames
    curReq = "R2";
    for (int f = 0; f < 3; f++) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        addrValid = 1'b1;
        addrFirst = (k == 0);
        addrOctet = (f == 1) ? STATION[8*k +: 8] : PHYS_X[8*k +: 8];
      end
    end
    @(negedge clk);
    addrValid = 1'b0;
    addrFirst = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired during %s", curReq);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule